// File: doc/BRIEF.md
# Five-Channel Pulse-Train Timer

This block is a counter/timer peripheral with five independent channels, each able to produce a square or rectangular pulse train on its own output. The host controls it through two ports: a byte-wide command port that carries encoded operations, and a 16-bit data port that reads and writes registers through an internal pointer.

Each channel has three registers: mode, load and hold. The pointer selects one of them. After each data access it steps from mode to load, then to hold, then on to the next channel. The pointer can also select a master mode register.

A chain of divide-by-ten stages turns a base tick into five count sources. An armed channel counts ticks of the source its mode selects. It alternates between a phase timed by its load value and a phase timed by its hold value, and it inverts its output at the end of each phase.

Top module: `quint_timer`

## Requirements
- R1: When `rst_n` is low at a clock edge, all outputs go to 0 and every channel is disarmed. The mode, load and hold registers clear to 0, the master register takes 0xA100, and the pointer selects channel 1's mode register.
- R2: Command 0x17 points at the master register, which can be read and written through the data port. Repeated data accesses stay on the master register.
- R3: Command n (n = 1..5) points at channel n's mode register. Each data read or write then advances the pointer: mode, then load, then hold, then the mode register of channel n+1. After channel 5 the pointer wraps to channel 1.
- R4: Command 0x40 | m copies the load register into the counter of every channel whose bit is set in the 5-bit mask m (bit i selects channel i+1). The next reload then comes from the hold register.
- R5: Command 0x20 | m arms the channels selected by m. On each counting tick, an armed channel whose count is 0 or 1 reloads from the register that is next in turn (hold after load, load after hold) and inverts its output; otherwise it decrements. Starting from output 0, the output rises after max(L,1) ticks, then stays high for max(H,1) ticks and low for max(L,1) ticks.
- R6: Mode bits 11:8 select the count source. Codes 0xB..0xF select F1..F5, where F1 is every `base_tick` and each later source ticks once per ten ticks of the one before. Any other code stops counting.
- R7: A channel counts only when the low byte of its mode register is 0x62. With any other value an armed channel keeps its count and its output.
- R8: Command 0xC0 | n disarms channel n. Its count and output level freeze, and re-arming resumes from the frozen count.
- R9: Command 0xE0 | n drives channel n's output to 0 and command 0xE8 | n drives it to 1, one cycle after the command. Either command overrides a toggle in that same cycle.
- R10: Command 0xFF restores the whole R1 state and restarts the divider chain.
- R11: Command 0xEF and every command byte not listed above leave the pointer, the registers, the arming and the outputs unchanged.
- R12: A command addressed to some channels leaves the outputs of the other channels unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | Enable for the fastest count source |
| cmd_we | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Encoded command |
| data_we | input | 1 | Write `data_in` to the selected register and advance the pointer |
| data_rd | input | 1 | Advance the pointer after reading `data_out` |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Contents of the selected register |
| tc_out | output | 5 | Channel outputs, bit i for channel i+1 |

## Verification
The bench sweeps load and hold values from 0 to 4 on rotating channels and times the first rise, the high width and the low width. A design that reloaded one tick late, treated a zero value as 65536, or swapped the phase order would get at least one of those lengths wrong. Each slower source is timed in clock cycles, which exposes a divider that is off by one or a source code that maps to the wrong tap. The pointer is walked across all fifteen channel registers and through the wrap from channel 5 to channel 1. A disarmed channel is re-armed to check that it resumes from its frozen count rather than restarting. Unlisted command bytes are sent to show that they neither move the pointer nor change any output.

// File: rtl/quint_timer_pkg.sv
`timescale 1ns/1ps
// quint_timer_pkg: constants and the decoded-command type shared by the
// timer's submodules. The command group codes fix the encoding that the host
// software relies on, so they are constants rather than parameters.
package quint_timer_pkg;

    localparam int NUM_CH  = 5;
    localparam int NUM_SRC = 5;

    localparam logic [3:0] SRC_CODE_FIRST  = 4'hB;
    localparam logic [7:0] MODE_ALT_TOGGLE = 8'h62;

    localparam logic [7:0] CMD_FULL_RESET = 8'hFF;
    localparam logic [7:0] CMD_PTR_MASTER = 8'h17;
    localparam logic [4:0] GRP_POINT      = 5'b00000;
    localparam logic [2:0] GRP_ARM        = 3'b001;
    localparam logic [2:0] GRP_LOAD       = 3'b010;
    localparam logic [4:0] GRP_DISARM     = 5'b11000;
    localparam logic [4:0] GRP_CLR        = 5'b11100;
    localparam logic [4:0] GRP_SET        = 5'b11101;

    typedef enum logic [1:0] {
        FLD_MODE = 2'd0,
        FLD_LOAD = 2'd1,
        FLD_HOLD = 2'd2
    } field_e;

    typedef struct packed {
        logic              full_rst;
        logic              ptr_master;
        logic              ptr_chan;
        logic [2:0]        ptr_idx;
        logic [NUM_CH-1:0] arm;
        logic [NUM_CH-1:0] load;
        logic [NUM_CH-1:0] disarm;
        logic [NUM_CH-1:0] clr_tc;
        logic [NUM_CH-1:0] set_tc;
    } cmd_t;

endpackage

// File: rtl/quint_cmd_decode.sv
`timescale 1ns/1ps
// quint_cmd_decode: turns one command byte into per-channel strobes.
// Purely combinational. Assumes cmd_byte is meaningful only while cmd_we is
// high. Bytes that match no group produce an all-zero result, which is a no-op.
module quint_cmd_decode
    import quint_timer_pkg::*;
(
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd
);

    logic              n_ok;
    logic [NUM_CH-1:0] chan_hot;

    // Decode the single-channel operand carried in the low three bits.
    always_comb begin
        n_ok     = (cmd_byte[2:0] >= 3'd1) && (cmd_byte[2:0] <= 3'(NUM_CH));
        chan_hot = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (n_ok && (cmd_byte[2:0] == 3'(i + 1))) begin
                chan_hot[i] = 1'b1;
            end
        end
    end

    // Classify the byte into exactly one operation group.
    always_comb begin
        cmd = '0;
        if (cmd_we) begin
            if (cmd_byte == CMD_FULL_RESET) begin
                cmd.full_rst = 1'b1;
            end else if (cmd_byte == CMD_PTR_MASTER) begin
                cmd.ptr_master = 1'b1;
            end else if ((cmd_byte[7:3] == GRP_POINT) && n_ok) begin
                cmd.ptr_chan = 1'b1;
                cmd.ptr_idx  = cmd_byte[2:0];
            end else if (cmd_byte[7:5] == GRP_ARM) begin
                cmd.arm = cmd_byte[NUM_CH-1:0];
            end else if (cmd_byte[7:5] == GRP_LOAD) begin
                cmd.load = cmd_byte[NUM_CH-1:0];
            end else if (cmd_byte[7:3] == GRP_DISARM) begin
                cmd.disarm = chan_hot;
            end else if (cmd_byte[7:3] == GRP_CLR) begin
                cmd.clr_tc = chan_hot;
            end else if (cmd_byte[7:3] == GRP_SET) begin
                cmd.set_tc = chan_hot;
            end
        end
    end

endmodule

// File: rtl/quint_prescaler.sv
`timescale 1ns/1ps
// quint_prescaler: a chain of divide-by-RATIO stages. Tap 0 is base_tick
// itself; tap k ticks once per RATIO ticks of tap k-1, in the same clock cycle
// as the tick of tap k-1 that completes the count. Assumes RATIO >= 2.
// The restart input clears every stage so the taps realign.
module quint_prescaler #(
    parameter int RATIO  = 10,
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              base_tick,
    output logic [STAGES-1:0] src_tick
);

    localparam int DIV_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RATIO - 1);

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic tick;
        if (k == 0) begin : g_base
            assign tick = base_tick;
        end else begin : g_div
            logic [DIV_W-1:0] div_q;
            logic             wrap;
            assign wrap = (div_q == DIV_LAST);
            // Count the previous tap's ticks and wrap after RATIO of them.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    div_q <= '0;
                end else if (g_stage[k-1].tick) begin
                    div_q <= wrap ? '0 : div_q + 1'b1;
                end
            end
            assign tick = g_stage[k-1].tick && wrap;
        end
        assign src_tick[k] = tick;
    end

endmodule

// File: rtl/quint_channel.sv
`timescale 1ns/1ps
// quint_channel: one counter channel with its mode, load and hold registers.
// When armed, with the alternating mode selected and a valid source, it counts
// down ticks. A tick on a count of 0 or 1 reloads from the register next in
// turn and inverts tc_q. Assumes CNT_W <= 16 and at most one command strobe
// per cycle.
module quint_channel
    import quint_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_mode,
    input  logic               wr_load,
    input  logic               wr_hold,
    input  logic [15:0]        wdata,
    input  logic               arm,
    input  logic               disarm,
    input  logic               load_cnt,
    input  logic               clr_tc,
    input  logic               set_tc,
    output logic [15:0]        mode_q,
    output logic [CNT_W-1:0]   load_q,
    output logic [CNT_W-1:0]   hold_q,
    output logic               armed_q,
    output logic               tc_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             next_hold_q;
    logic [3:0]       src_code;
    logic [3:0]       src_off;
    logic             sel_tick;
    logic             count_en;
    logic             terminal;

    assign src_code = mode_q[11:8];
    assign src_off  = src_code - SRC_CODE_FIRST;

    // Pick the tick of the source named by the mode word, if it names one.
    always_comb begin
        sel_tick = 1'b0;
        if (src_code >= SRC_CODE_FIRST) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (src_off == 4'(i)) begin
                    sel_tick = src_tick[i];
                end
            end
        end
    end

    assign count_en = armed_q && sel_tick && (mode_q[7:0] == MODE_ALT_TOGGLE);
    assign terminal = (count_q <= CNT_ONE);

    // Host-visible register file of this channel.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mode_q <= '0;
            load_q <= '0;
            hold_q <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata;
            if (wr_load) load_q <= wdata[CNT_W-1:0];
            if (wr_hold) hold_q <= wdata[CNT_W-1:0];
        end
    end

    // Arm state: set by arm, cleared by disarm.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            armed_q <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
        end else if (disarm) begin
            armed_q <= 1'b0;
        end
    end

    // Down-counter with alternating reload source.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q     <= '0;
            next_hold_q <= 1'b0;
        end else if (load_cnt) begin
            count_q     <= load_q;
            next_hold_q <= 1'b1;
        end else if (count_en) begin
            if (terminal) begin
                count_q     <= next_hold_q ? hold_q : load_q;
                next_hold_q <= !next_hold_q;
            end else begin
                count_q <= count_q - CNT_ONE;
            end
        end
    end

    // Output level: inverted at each terminal tick; host set/clear take priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tc_q <= 1'b0;
        end else if (set_tc) begin
            tc_q <= 1'b1;
        end else if (clr_tc) begin
            tc_q <= 1'b0;
        end else if (count_en && terminal) begin
            tc_q <= !tc_q;
        end
    end

endmodule

// File: rtl/quint_timer.sv
`timescale 1ns/1ps
// quint_timer: five-channel pulse-train timer. Owns the data pointer and the
// master register; the channels, divider chain and command decoder are
// submodules. Assumes the host does not issue a command and a data access in
// the same cycle. If it does, the data access uses the old pointer and the
// command's pointer move wins.
module quint_timer
    import quint_timer_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          SRC_RATIO   = 10,
    parameter logic [15:0] MASTER_INIT = 16'hA100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              data_we,
    input  logic              data_rd,
    input  logic [15:0]       data_in,
    output logic [15:0]       data_out,
    output logic [NUM_CH-1:0] tc_out
);

    localparam int PTR_W = $clog2(NUM_CH + 1);
    localparam logic [PTR_W-1:0] PTR_MASTER = '0;
    localparam logic [PTR_W-1:0] PTR_FIRST  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST   = PTR_W'(NUM_CH);

    cmd_t               cmd;
    logic [NUM_SRC-1:0] src_tick;
    logic [PTR_W-1:0]   ptr_ch_q;
    field_e             ptr_fld_q;
    logic [15:0]        master_q;
    logic               access;
    logic [NUM_CH-1:0]  chan_armed;
    logic [15:0]        mode_arr [NUM_CH];
    logic [CNT_W-1:0]   load_arr [NUM_CH];
    logic [CNT_W-1:0]   hold_arr [NUM_CH];

    assign access = data_we || data_rd;

    quint_cmd_decode u_decode (
        .cmd_we   (cmd_we),
        .cmd_byte (cmd_byte),
        .cmd      (cmd)
    );

    quint_prescaler #(
        .RATIO  (SRC_RATIO),
        .STAGES (NUM_SRC)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cmd.full_rst),
        .base_tick (base_tick),
        .src_tick  (src_tick)
    );

    // Data pointer: set by commands, stepped by data-port accesses.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.full_rst) begin
            ptr_ch_q  <= PTR_FIRST;
            ptr_fld_q <= FLD_MODE;
        end else if (cmd.ptr_master) begin
            ptr_ch_q  <= PTR_MASTER;
            ptr_fld_q <= FLD_MODE;
        end else if (cmd.ptr_chan) begin
            ptr_ch_q  <= PTR_W'(cmd.ptr_idx);
            ptr_fld_q <= FLD_MODE;
        end else if (access && (ptr_ch_q != PTR_MASTER)) begin
            case (ptr_fld_q)
                FLD_MODE: ptr_fld_q <= FLD_LOAD;
                FLD_LOAD: ptr_fld_q <= FLD_HOLD;
                default: begin
                    ptr_fld_q <= FLD_MODE;
                    ptr_ch_q  <= (ptr_ch_q == PTR_LAST) ? PTR_FIRST : ptr_ch_q + 1'b1;
                end
            endcase
        end
    end

    // Master mode register: plain storage reached when the pointer is parked on it.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.full_rst) begin
            master_q <= MASTER_INIT;
        end else if (data_we && (ptr_ch_q == PTR_MASTER)) begin
            master_q <= data_in;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic sel;
        assign sel = (ptr_ch_q == PTR_W'(i + 1));

        quint_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (cmd.full_rst),
            .src_tick (src_tick),
            .wr_mode  (data_we && sel && (ptr_fld_q == FLD_MODE)),
            .wr_load  (data_we && sel && (ptr_fld_q == FLD_LOAD)),
            .wr_hold  (data_we && sel && (ptr_fld_q == FLD_HOLD)),
            .wdata    (data_in),
            .arm      (cmd.arm[i]),
            .disarm   (cmd.disarm[i]),
            .load_cnt (cmd.load[i]),
            .clr_tc   (cmd.clr_tc[i]),
            .set_tc   (cmd.set_tc[i]),
            .mode_q   (mode_arr[i]),
            .load_q   (load_arr[i]),
            .hold_q   (hold_arr[i]),
            .armed_q  (chan_armed[i]),
            .tc_q     (tc_out[i])
        );
    end

    // Read mux: the register under the pointer.
    always_comb begin
        data_out = '0;
        if (ptr_ch_q == PTR_MASTER) begin
            data_out = master_q;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ptr_ch_q == PTR_W'(i + 1)) begin
                    case (ptr_fld_q)
                        FLD_MODE: data_out = mode_arr[i];
                        FLD_LOAD: data_out = 16'(load_arr[i]);
                        default:  data_out = 16'(hold_arr[i]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/quint_timer_chk.sv
`timescale 1ns/1ps
// quint_timer_chk: temporal properties of the timer, attached by bind.
// Observes the command port, the outputs and the per-channel arm state.
module quint_timer_chk
    import quint_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [7:0]        cmd_byte,
    input logic [NUM_CH-1:0] tc_out,
    input logic [NUM_CH-1:0] armed
);

    // R10: a full reset command disarms everything and clears every output.
    p_full_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hFF) |=> (tc_out == '0 && armed == '0));

    // R5: an arm command sets the arm bit of every masked channel.
    p_arm_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:5] == 3'b001)
        |=> ((armed & $past(cmd_byte[4:0])) == $past(cmd_byte[4:0])));

    // R11: the bus-width command leaves arming untouched.
    p_noop_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hEF) |=> $stable(armed));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [7:0] SET_CODE = 8'hE8 + 8'(i + 1);
        localparam logic [7:0] CLR_CODE = 8'hE0 + 8'(i + 1);
        localparam logic [7:0] DIS_CODE = 8'hC0 + 8'(i + 1);

        // R9: the set command drives the output high in the next cycle.
        p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_we && cmd_byte == SET_CODE) |=> tc_out[i]);

        // R9: the clear command drives the output low in the next cycle.
        p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_we && cmd_byte == CLR_CODE) |=> !tc_out[i]);

        // R8: the disarm command drops the arm bit.
        p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_we && cmd_byte == DIS_CODE) |=> !armed[i]);

        // R8: a disarmed channel holds its level unless set, cleared or reset.
        p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed[i] && !(cmd_we && (cmd_byte == SET_CODE || cmd_byte == CLR_CODE
                                       || cmd_byte == 8'hFF)))
            |=> $stable(tc_out[i]));
    end

endmodule

bind quint_timer quint_timer_chk u_quint_timer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_byte (cmd_byte),
    .tc_out   (tc_out),
    .armed    (chan_armed)
);

// File: tb/test_quint_timer.sv
`timescale 1ns/1ps
module test_quint_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b1;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        data_we = 1'b0;
    logic        data_rd = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic [4:0]  tc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    quint_timer i_quint_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .cmd_we    (cmd_we),
        .cmd_byte  (cmd_byte),
        .data_we   (data_we),
        .data_rd   (data_rd),
        .data_in   (data_in),
        .data_out  (data_out),
        .tc_out    (tc_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        cmd_we = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_we = 1'b0; cmd_byte = '0;
    endtask

    task automatic wr(input logic [15:0] d);
        data_we = 1'b1; data_in = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int exp);
        chk(tag, int'(data_out), exp);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic setup(input int n, input logic [15:0] mode, input int l, input int h);
        send(8'(n));
        wr(mode);
        wr(16'(l));
        wr(16'(h));
    endtask

    task automatic run_len(input int c, input logic lvl, input int lim, output int n);
        n = 0;
        while (tc_out[c] == lvl && n < lim) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic int at_least1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 tc after reset", int'(tc_out), 0);
        rd_chk("R1 ch1 mode after reset", 0);
        send(8'h17);
        rd_chk("R1 master after reset", 16'hA100);

        // R2: master read/write, pointer parks there
        wr(16'h1234);
        rd_chk("R2 master write", 16'h1234);
        rd_chk("R2 master stays", 16'h1234);

        // R3: write through all channels with one pointer command, read back with wrap
        send(8'h01);
        for (int c = 1; c <= 5; c++) begin
            wr(16'(16'h0B60 + c));
            wr(16'(100 + c));
            wr(16'(200 + c));
        end
        send(8'h01);
        for (int c = 1; c <= 5; c++) begin
            rd_chk("R3 mode", 16'h0B60 + c);
            rd_chk("R3 load", 100 + c);
            rd_chk("R3 hold", 200 + c);
        end
        rd_chk("R3 wrap to ch1 mode", 16'h0B61);

        // R11: unlisted bytes change neither pointer nor outputs
        send(8'h03);
        rd_chk("R3 ch3 mode", 16'h0B63);
        send(8'hEF); send(8'h00); send(8'h06); send(8'h80); send(8'h1F); send(8'hC7);
        rd_chk("R11 pointer kept at ch3 load", 103);
        chk("R11 outputs unchanged", int'(tc_out), 0);

        // R10: full reset while a channel runs
        send(8'h17);
        wr(16'h5555);
        setup(1, 16'h0B62, 1, 1);
        send(8'h41); send(8'h21);
        idle(3);
        send(8'hFF);
        chk("R10 outputs cleared", int'(tc_out), 0);
        rd_chk("R10 ch1 mode cleared, pointer ch1", 0);
        idle(20);
        chk("R10 channel disarmed", int'(tc_out), 0);
        send(8'h17);
        rd_chk("R10 master restored", 16'hA100);

        // R4 R5 R12: sweep load and hold values on rotating channels
        for (int l = 0; l <= 4; l++) begin
            for (int h = 0; h <= 4; h++) begin
                int c;
                c = (l + h) % 5;
                send(8'hFF);
                setup(c + 1, 16'h0B62, l, h);
                send(8'(8'h40 | (1 << c)));
                send(8'(8'h20 | (1 << c)));
                run_len(c, 1'b0, 100, n);
                chk($sformatf("R5 rise L%0d H%0d", l, h), n, at_least1(l));
                chk("R12 others idle", int'(tc_out & ~5'(1 << c)), 0);
                run_len(c, 1'b1, 100, n);
                chk($sformatf("R5 high L%0d H%0d", l, h), n, at_least1(h));
                run_len(c, 1'b0, 100, n);
                chk($sformatf("R4 low L%0d H%0d", l, h), n, at_least1(l));
            end
        end

        // R4: bitmask load and arm start two channels together
        send(8'hFF);
        setup(1, 16'h0B62, 3, 2);
        setup(2, 16'h0B62, 3, 2);
        send(8'h43); send(8'h23);
        run_len(0, 1'b0, 100, n);
        chk("R4 mask ch1 rise", n, 3);
        chk("R4 mask ch2 rises with ch1", int'(tc_out), 3);

        // R6: slower sources, timed in clock cycles
        for (int s = 1; s <= 4; s++) begin
            int div;
            div = (s == 1) ? 10 : (s == 2) ? 100 : (s == 3) ? 1000 : 10000;
            send(8'hFF);
            setup(s + 1, 16'(16'h0B62 + (s << 8)), 1, 2);
            send(8'(8'h40 | (1 << s)));
            send(8'(8'h20 | (1 << s)));
            run_len(s, 1'b0, 30000, n);
            run_len(s, 1'b1, 30000, n);
            chk($sformatf("R6 high F%0d", s + 1), n, 2 * div);
            run_len(s, 1'b0, 30000, n);
            chk($sformatf("R6 low F%0d", s + 1), n, div);
        end
        send(8'hFF);
        setup(1, 16'h0A62, 1, 1);
        send(8'h41); send(8'h21);
        idle(50);
        chk("R6 invalid source code stops counting", int'(tc_out), 0);

        // R7: wrong mode low byte prevents counting
        send(8'hFF);
        setup(1, 16'h0B00, 1, 1);
        send(8'h41); send(8'h21);
        idle(20);
        chk("R7 no count in other mode", int'(tc_out), 0);

        // R8: disarm freezes count and level; re-arm resumes
        send(8'hFF);
        setup(4, 16'h0B62, 4, 4);
        send(8'h48); send(8'h28);
        idle(2);
        send(8'hC4);
        idle(20);
        chk("R8 frozen low", int'(tc_out), 0);
        send(8'h28);
        run_len(3, 1'b0, 100, n);
        chk("R8 resume from frozen count", n, 1);
        idle(1);
        send(8'hC4);
        idle(20);
        chk("R8 frozen high", int'(tc_out), 8);

        // R9 R12: direct set and clear on one channel
        send(8'hFF);
        send(8'hEB);
        chk("R9 set ch3", int'(tc_out), 4);
        send(8'hE3);
        chk("R9 clear ch3", int'(tc_out), 0);
        send(8'hE9); send(8'hED);
        chk("R12 set ch1 and ch5 only", int'(tc_out), 17);
        send(8'hE1);
        chk("R12 clear ch1 keeps ch5", int'(tc_out), 16);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule